// File: doc/BRIEF.md
# Tachometer Speed Discriminator with Lock Detect

This block measures a motor's tachometer period in units of a reference tick. The tick runs at 512 times the commanded clock rate, so a motor turning at the commanded speed produces exactly 512 ticks per tachometer period. The block reports three things. The first is a speed-error pulse with a direction bit; its length tells an integrator how far the period is from nominal. The second is an active-low in-lock flag for a ±6.25 % window around nominal. The third is a tri-level phase comparison between the command clock edges and the tachometer edges.

The speed result is issued only on every second measured period. The phase comparison runs on every tachometer period. The reference tick arrives as a clock enable. The tachometer and command edges arrive as single-cycle pulses that are already synchronised to `clk`. The loop filter, the integrator and the oscillator that makes the reference are outside this block.

Top module: `fgsd_speed_disc`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `lock_n` is 1 and `spd_pulse`, `phase_up` and `phase_dn` are 0.
- R2: A measured period is the number of `ref_tick` cycles after one `fg_edge` cycle, up to and including the next `fg_edge` cycle. The first `fg_edge` after reset only starts a measurement and yields no result.
- R3: Only the second, fourth, sixth and later measured periods are evaluated. Their result appears on the outputs in the cycle after the `fg_edge` that closes them. Odd-numbered periods leave `spd_pulse`, `spd_accel` and `lock_n` unchanged.
- R4: On evaluation, `spd_accel` becomes 1 when the count is above 512 and 0 when it is below 512. It then holds until the next evaluation. A count of exactly 512 gives no pulse.
- R5: On evaluation, `spd_pulse` goes high for W consecutive cycles. W is |count − 512|, limited to `max_width`. W = 0 gives no pulse. A new evaluation restarts the pulse.
- R6: On evaluation, `lock_n` goes to 0 if 480 ≤ count ≤ 544 and to 1 otherwise. It holds until the next evaluation.
- R7: The period count stops at 2047 (all ones in 11 bits). A stopped count is judged as accelerate and out of lock.
- R8: Phase encoding: `phase_up`=1 means the command leads, `phase_dn`=1 means the tachometer leads, and both 0 means idle. From idle, a lone `cmd_edge` gives up and a lone `fg_edge` gives down, from the next cycle. A lone `fg_edge` ends up. A lone `cmd_edge` ends down.
- R9: When `cmd_edge` and `fg_edge` arrive in the same cycle, the phase state is unchanged: idle stays idle, up stays up and down stays down.
- R10: A further `cmd_edge` while up, or a further `fg_edge` while down, keeps the state.
- R11: The period count advances only in cycles where `ref_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | Reference count enable (512 × command rate) |
| fg_edge | input | 1 | Tachometer edge pulse |
| cmd_edge | input | 1 | Command clock edge pulse |
| max_width | input | PW_W | Upper limit on speed-error pulse length, in cycles |
| spd_pulse | output | 1 | Speed-error pulse |
| spd_accel | output | 1 | Direction: 1 accelerate, 0 decelerate |
| lock_n | output | 1 | 0 while the last evaluated period was in the lock window |
| phase_up | output | 1 | Command clock leads the tachometer |
| phase_dn | output | 1 | Tachometer leads the command clock |

## Verification
The bench walks the lock window edge by edge, with periods of 479, 480, 544 and 545 counts. A design with an off-by-one bound would flag lock on the wrong side of one of these. It checks that the first edge after reset and every odd period stay silent. A design that evaluates every period, or counts the arming edge as a period, would move `lock_n` one period early. It stalls the tachometer until the counter stops and shrinks `max_width` to show that a wrapping counter or a missing clip yields a short or decelerating pulse. Runs at half tick rate, and cases where both edges land in one cycle, catch counting on non-tick cycles and a phase machine that gives one edge priority over the other.

// File: rtl/fgsd_pkg.sv
package fgsd_pkg;

    // Default sizing of the discriminator.
    localparam int CNT_W_DEF   = 11;   // period counter width
    localparam int PW_W_DEF    = 10;   // pulse width / clip width
    localparam int NOMINAL_DEF = 512;  // ticks per nominal tachometer period

    // Tri-level phase comparator state.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_UP   = 2'd1,
        PH_DOWN = 2'd2
    } phase_e;

    // Edge events seen by the phase comparator in one cycle.
    typedef struct packed {
        logic cmd;
        logic fg;
    } edge_evt_t;

    // Verdict formed from one evaluated period.
    typedef struct packed {
        logic accel;
        logic locked;
    } spd_verdict_t;

    // Next phase state from the current state and the edges of this cycle.
    function automatic phase_e phase_next(input phase_e cur, input edge_evt_t ev);
        phase_e nxt;
        nxt = cur;
        unique case (cur)
            PH_IDLE: begin
                if (ev.cmd && !ev.fg)      nxt = PH_UP;
                else if (ev.fg && !ev.cmd) nxt = PH_DOWN;
            end
            PH_UP:   if (ev.fg && !ev.cmd) nxt = PH_IDLE;
            PH_DOWN: if (ev.cmd && !ev.fg) nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/fgsd_period_meter.sv
module fgsd_period_meter #(
    parameter int CNT_W = fgsd_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             fg_edge,
    output logic             meas_eval,
    output logic             meas_sat,
    output logic [CNT_W-1:0] meas_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             armed_q;   // a period is in progress
    logic             odd_q;     // next closed period is the evaluated one

    // Count including the tick of this cycle, held at the ceiling.
    always_comb begin
        if (ref_tick && (cnt_q != CNT_MAX)) cnt_inc = cnt_q + 1'b1;
        else                                cnt_inc = cnt_q;
    end

    assign meas_count = cnt_inc;
    assign meas_sat   = (cnt_inc == CNT_MAX);
    assign meas_eval  = fg_edge && armed_q && odd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            odd_q   <= 1'b0;
        end else if (fg_edge) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
            if (armed_q) odd_q <= ~odd_q;
        end else begin
            cnt_q <= cnt_inc;
        end
    end
endmodule

// File: rtl/fgsd_speed_eval.sv
module fgsd_speed_eval #(
    parameter int CNT_W   = fgsd_pkg::CNT_W_DEF,
    parameter int PW_W    = fgsd_pkg::PW_W_DEF,
    parameter int NOMINAL = fgsd_pkg::NOMINAL_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eval,
    input  logic             sat,
    input  logic [CNT_W-1:0] count,
    input  logic [PW_W-1:0]  max_width,
    output logic             spd_pulse,
    output logic             spd_accel,
    output logic             lock_n
);
    import fgsd_pkg::*;

    localparam int TOL  = NOMINAL / 16;           // 6.25 % of nominal
    localparam int DW   = (CNT_W > PW_W) ? CNT_W : PW_W;
    localparam logic [CNT_W-1:0] NOM_C  = CNT_W'(NOMINAL);
    localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(NOMINAL - TOL);
    localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(NOMINAL + TOL);

    logic             above;
    logic [CNT_W-1:0] diff;
    logic [DW-1:0]    diff_x;
    logic [DW-1:0]    cap_x;
    logic [PW_W-1:0]  width;
    spd_verdict_t     verdict;

    logic [PW_W-1:0]  pw_q;
    logic             accel_q;
    logic             lock_n_q;

    always_comb begin
        above  = (count > NOM_C);
        diff   = above ? (count - NOM_C) : (NOM_C - count);
        diff_x = DW'(diff);
        cap_x  = DW'(max_width);
        width  = (diff_x > cap_x) ? max_width : PW_W'(diff_x);
        verdict.accel  = above || sat;
        verdict.locked = !sat && (count >= LOW_C) && (count <= HIGH_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pw_q     <= '0;
            accel_q  <= 1'b0;
            lock_n_q <= 1'b1;
        end else if (eval) begin
            pw_q     <= width;
            accel_q  <= verdict.accel;
            lock_n_q <= ~verdict.locked;
        end else if (pw_q != '0) begin
            pw_q <= pw_q - 1'b1;
        end
    end

    assign spd_pulse = (pw_q != '0);
    assign spd_accel = accel_q;
    assign lock_n    = lock_n_q;
endmodule

// File: rtl/fgsd_phase_cmp.sv
module fgsd_phase_cmp (
    input  logic clk,
    input  logic rst,
    input  logic cmd_edge,
    input  logic fg_edge,
    output logic phase_up,
    output logic phase_dn
);
    import fgsd_pkg::*;

    phase_e    state_q;
    edge_evt_t ev;

    always_comb begin
        ev.cmd = cmd_edge;
        ev.fg  = fg_edge;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_IDLE;
        else     state_q <= phase_next(state_q, ev);
    end

    assign phase_up = (state_q == PH_UP);
    assign phase_dn = (state_q == PH_DOWN);
endmodule

// File: rtl/fgsd_speed_disc.sv
module fgsd_speed_disc #(
    parameter int CNT_W   = fgsd_pkg::CNT_W_DEF,
    parameter int PW_W    = fgsd_pkg::PW_W_DEF,
    parameter int NOMINAL = fgsd_pkg::NOMINAL_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_tick,
    input  logic            fg_edge,
    input  logic            cmd_edge,
    input  logic [PW_W-1:0] max_width,
    output logic            spd_pulse,
    output logic            spd_accel,
    output logic            lock_n,
    output logic            phase_up,
    output logic            phase_dn
);
    logic             meas_eval;
    logic             meas_sat;
    logic [CNT_W-1:0] meas_count;

    fgsd_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .fg_edge   (fg_edge),
        .meas_eval (meas_eval),
        .meas_sat  (meas_sat),
        .meas_count(meas_count)
    );

    fgsd_speed_eval #(.CNT_W(CNT_W), .PW_W(PW_W), .NOMINAL(NOMINAL)) u_eval (
        .clk       (clk),
        .rst       (rst),
        .eval      (meas_eval),
        .sat       (meas_sat),
        .count     (meas_count),
        .max_width (max_width),
        .spd_pulse (spd_pulse),
        .spd_accel (spd_accel),
        .lock_n    (lock_n)
    );

    fgsd_phase_cmp u_phase (
        .clk      (clk),
        .rst      (rst),
        .cmd_edge (cmd_edge),
        .fg_edge  (fg_edge),
        .phase_up (phase_up),
        .phase_dn (phase_dn)
    );
endmodule

// File: rtl/fgsd_speed_disc_chk.sv
module fgsd_speed_disc_chk (
    input logic clk,
    input logic rst,
    input logic fg_edge,
    input logic cmd_edge,
    input logic spd_pulse,
    input logic spd_accel,
    input logic lock_n,
    input logic phase_up,
    input logic phase_dn
);
    // Reset leaves every output quiet on the following cycle.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (lock_n && !spd_pulse && !phase_up && !phase_dn));

    // A speed pulse can only start right after a tachometer edge.
    assert_pulse_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(spd_pulse) |-> $past(fg_edge));

    // Direction only moves on an evaluating edge.
    assert_dir_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(spd_accel) |-> $past(fg_edge));

    // Lock flag only moves on an evaluating edge.
    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_n) |-> $past(fg_edge));

    // Up and down are never active together.
    assert_phase_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(phase_up && phase_dn));

    // Up is entered only on a command edge, down only on a tachometer edge.
    assert_up_entry_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_up) |-> ($past(cmd_edge) && !$past(fg_edge)));

    assert_dn_entry_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_dn) |-> ($past(fg_edge) && !$past(cmd_edge)));
endmodule

bind fgsd_speed_disc fgsd_speed_disc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .fg_edge  (fg_edge),
    .cmd_edge (cmd_edge),
    .spd_pulse(spd_pulse),
    .spd_accel(spd_accel),
    .lock_n   (lock_n),
    .phase_up (phase_up),
    .phase_dn (phase_dn)
);

// File: tb/tb_fgsd_speed_disc.sv
module tb_fgsd_speed_disc;
    localparam int NOM  = 512;
    localparam int LO   = 480;
    localparam int HI   = 544;
    localparam int CMAX = 2047;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic       fg_edge = 1'b0;
    logic       cmd_edge = 1'b0;
    logic [9:0] max_width = 10'd1023;
    logic       spd_pulse, spd_accel, lock_n, phase_up, phase_dn;

    always #5 clk = ~clk;

    fgsd_speed_disc dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .fg_edge(fg_edge),
        .cmd_edge(cmd_edge), .max_width(max_width), .spd_pulse(spd_pulse),
        .spd_accel(spd_accel), .lock_n(lock_n), .phase_up(phase_up),
        .phase_dn(phase_dn)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    int    cyc      = 0;
    int    tick_div = 1;
    int    run_len  = 0;
    int    last_run = 0;
    string cur_tag  = "R1";

    // Behavioural reference model.
    int m_cnt = 0, m_armed = 0, m_odd = 0, m_pw = 0, m_acc = 0, m_lockn = 1, m_ph = 0;

    always @(posedge clk) begin
        int m, d, ev;
        if (rst) begin
            m_cnt = 0; m_armed = 0; m_odd = 0; m_pw = 0; m_acc = 0; m_lockn = 1; m_ph = 0;
        end else begin
            m = m_cnt + (ref_tick ? 1 : 0);
            if (m > CMAX) m = CMAX;
            ev = 0;
            if (fg_edge) begin
                if (m_armed != 0) begin
                    if (m_odd != 0) ev = 1;
                    m_odd = 1 - m_odd;
                end
                m_armed = 1;
                m_cnt = 0;
            end else begin
                m_cnt = m;
            end
            if (ev != 0) begin
                d = (m > NOM) ? m - NOM : NOM - m;
                m_pw = (d > int'(max_width)) ? int'(max_width) : d;
                m_acc = (m > NOM) ? 1 : 0;
                m_lockn = (m >= LO && m <= HI) ? 0 : 1;
            end else if (m_pw > 0) begin
                m_pw = m_pw - 1;
            end
            case (m_ph)
                0: if (cmd_edge && !fg_edge) m_ph = 1;
                   else if (fg_edge && !cmd_edge) m_ph = 2;
                1: if (fg_edge && !cmd_edge) m_ph = 0;
                default: if (cmd_edge && !fg_edge) m_ph = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(spd_pulse == (m_pw != 0), {cur_tag, "/R5"}, "spd_pulse", int'(spd_pulse), int'(m_pw != 0));
        chk(int'(spd_accel) == m_acc, {cur_tag, "/R4"}, "spd_accel", int'(spd_accel), m_acc);
        chk(int'(lock_n) == m_lockn, {cur_tag, "/R6"}, "lock_n", int'(lock_n), m_lockn);
        chk(phase_up == (m_ph == 1) && phase_dn == (m_ph == 2), {cur_tag, "/R8"}, "phase up/dn",
            int'({phase_up, phase_dn}), (m_ph == 1) ? 2 : (m_ph == 2) ? 1 : 0);
    endtask

    task automatic step(input logic f, input logic c);
        @(negedge clk);
        compare();
        if (spd_pulse) run_len++;
        else if (run_len > 0) begin last_run = run_len; run_len = 0; end
        fg_edge  = f;
        cmd_edge = c;
        ref_tick = ((cyc % tick_div) == 0);
        cyc++;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic run_fg(input int per, input int reps, input int cmd_off);
        for (int r = 0; r < reps; r++)
            for (int i = 0; i < per; i++)
                step(i == per - 1, i == cmd_off);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    // Two periods (second evaluated), then let the pulse finish and check.
    task automatic scen(input int per, input int exp_lockn, input int exp_acc, input int exp_w, input string tag);
        cur_tag  = tag;
        run_len  = 0;
        last_run = 0;
        run_fg(per, 2, -1);
        idle(70);
        chk(int'(lock_n) == exp_lockn, tag, "lock_n after evaluation", int'(lock_n), exp_lockn);
        if (exp_w > 0)
            chk(int'(spd_accel) == exp_acc, tag, "direction after evaluation", int'(spd_accel), exp_acc);
        chk(last_run == exp_w, tag, "pulse length", last_run, exp_w);
    endtask

    task automatic phase_chk(input logic f, input logic c, input int up, input int dn, input string tag);
        cur_tag = tag;
        step(f, c);
        settle();
        chk(int'(phase_up) == up && int'(phase_dn) == dn, tag, "phase state",
            int'({phase_up, phase_dn}), up * 2 + dn);
    endtask

    initial begin
        repeat (4) step(0, 0);
        settle();
        chk(lock_n && !spd_pulse && !phase_up && !phase_dn, "R1", "outputs in reset",
            int'({lock_n, spd_pulse, phase_up, phase_dn}), 8);
        step(0, 0);
        rst = 1'b0;

        // R2 / R3: arming edge and first measured period give no result.
        cur_tag = "R2";
        run_fg(512, 2, -1);
        settle();
        chk(lock_n == 1'b1, "R3", "lock_n after unevaluated period", int'(lock_n), 1);
        cur_tag = "R3";
        run_fg(512, 1, -1);
        settle();
        chk(lock_n == 1'b0, "R2", "lock_n after first evaluated 512-count period", int'(lock_n), 0);
        idle(20);

        scen(500, 0, 0, 12, "R5");
        scen(540, 0, 1, 28, "R4");
        scen(479, 1, 0, 33, "R6");
        scen(480, 0, 0, 32, "R6");
        scen(544, 0, 1, 32, "R6");
        scen(545, 1, 1, 33, "R6");
        scen(470, 1, 0, 42, "R4");
        scen(560, 1, 1, 48, "R4");
        scen(512, 0, 0, 0,  "R4");
        max_width = 10'd30;
        scen(600, 1, 1, 30, "R5");
        max_width = 10'd20;
        scen(2100, 1, 1, 20, "R7");
        max_width = 10'd1023;
        tick_div = 2;
        scen(1024, 0, 0, 0,  "R11");
        scen(1100, 1, 1, 38, "R11");
        tick_div = 1;

        // Phase comparator sequences; state starts in down.
        phase_chk(0, 1, 0, 0, "R8");
        phase_chk(0, 1, 1, 0, "R8");
        phase_chk(0, 1, 1, 0, "R10");
        phase_chk(1, 1, 1, 0, "R9");
        phase_chk(1, 0, 0, 0, "R8");
        phase_chk(1, 0, 0, 1, "R8");
        phase_chk(1, 0, 0, 1, "R10");
        phase_chk(1, 1, 0, 1, "R9");
        phase_chk(0, 1, 0, 0, "R8");
        phase_chk(1, 1, 0, 0, "R9");
        cur_tag = "R8";
        run_fg(512, 2, 100);
        idle(600);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule